// File: doc/BRIEF.md
# NAND Page Image Formatter

This block turns a 2048-byte host data page into the 2112-byte image that is programmed into a NAND page, and turns such an image back into host data. In format mode it accepts bytes on a valid/ready stream, emits every user byte bitwise inverted, and then appends a 64-byte spare area of its own making. The spare area holds one 16-byte group for each 512-byte sector. Each group records the logical block number, the page index inside the 128-page erase block, a tag byte and a 12-byte field set aside for ECC. The ECC value itself is not computed here. Those bytes are taken from a side input or written as zero.

In read mode the same datapath consumes a whole 2112-byte image. It returns the 2048 data bytes re-inverted and discards the spare area. From the first spare group it decodes the block number and page index. A start pulse latches the mode and the header fields for one page, and a single-cycle done pulse marks the end of that page.

Top module: `nand_page_fmt`

## Requirements
- R1: In format mode each of the first 2048 output bytes equals the bitwise inverse of the matching input byte, in arrival order (0x77 becomes 0x88, 0x00 becomes 0xFF).
- R2: A format page produces exactly 2112 output bytes: the 2048 data bytes first, then the 64 spare bytes.
- R3: Spare byte 16*g+k (g = 0..3) is: k=0 block number bits [7:0]; k=1 {tag[7:2], block number bits [9:8]}; k=2 page index zero-extended to 8 bits; k=3 the full tag byte. Spare bytes are never inverted.
- R4: Spare bytes with k = 4..15 carry `ecc_byte` when `ecc_en` was high at start, and 0x00 otherwise.
- R5: In format mode, no input byte is accepted once 2048 have been taken (`in_ready` stays low during the spare area and after the page).
- R6: Mode, block number, page index, tag and ECC enable are captured at an accepted start. Later changes of these inputs, and start pulses while a page is in progress, have no effect on that page.
- R7: `page_done` is high for exactly one cycle per page. In format mode it comes in the cycle after byte 2111 enters the output register. In read mode it comes in the cycle after input byte 2111 is taken. The block is idle while `page_done` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. Under any mix of input and output stalls, no byte is dropped or duplicated.
- R9: In read mode the block takes exactly 2112 input bytes and outputs exactly 2048 bytes, each the inverse of the matching input data byte.
- R10: After a read page, `rd_blk` equals {spare byte 1 bits [1:0], spare byte 0} and `rd_page` equals spare byte 2 bits [6:0] of the first spare group, and both are valid when `page_done` is high.
- R11: After reset `out_valid`, `in_ready` and `page_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a page when the block is idle |
| mode | input | 1 | 0 = format (write image), 1 = read back |
| blk_num | input | 10 | Logical block number for the spare groups |
| page_idx | input | 7 | Page index within the erase block |
| tag | input | 8 | Tag byte for the spare groups |
| ecc_en | input | 1 | Use `ecc_byte` for the ECC field instead of zero |
| ecc_byte | input | 8 | ECC field value, sampled as each ECC byte is produced |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink accepts the output byte this cycle |
| page_done | output | 1 | One-cycle end-of-page pulse |
| rd_blk | output | 10 | Block number decoded in read mode |
| rd_page | output | 7 | Page index decoded in read mode |

## Verification
The bench builds the block with its default parameters: 2048 data bytes, 512-byte sectors, 16-byte groups, a 10-bit block number and a 7-bit page index. These are the values the spare layout depends on, so the packed block number bits, the highest block number 0x3FF and the last page index 127 are all reached. Full-rate pages and pages with random input and output stalls cover the skid between input and output. A restart pulse and changing header inputs in the middle of a page show that latched fields are held.

// File: rtl/nand_fmt_pkg.sv
package nand_fmt_pkg;

  typedef logic [7:0] byte_t;

  // Position of each header field inside a 16-byte spare group.
  localparam int unsigned POS_BLK_LO = 0;
  localparam int unsigned POS_BLK_HI = 1;
  localparam int unsigned POS_PAGE   = 2;
  localparam int unsigned POS_TAG    = 3;

  function automatic byte_t flip(input byte_t b);
    return ~b;
  endfunction

endpackage

// File: rtl/nand_fmt_seq.sv
module nand_fmt_seq #(
  parameter int unsigned DATA_BYTES  = 2048,
  parameter int unsigned TOTAL_BYTES = 2112,
  localparam int unsigned IDX_W      = $clog2(TOTAL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_i,
  input  logic             in_valid,
  input  logic             out_slot,
  output logic             busy,
  output logic             mode_q,
  output logic [IDX_W-1:0] idx,
  output logic             in_phase,
  output logic             in_ready,
  output logic             take,
  output logic             emit,
  output logic             accept,
  output logic             page_done
);

  logic step;
  logic last;

  assign in_phase = idx < IDX_W'(DATA_BYTES);
  assign accept   = start && !busy;
  // data bytes need an output slot; spare bytes are swallowed in read mode only
  assign in_ready = busy && (in_phase ? out_slot : mode_q);
  assign take     = in_ready && in_valid;
  assign emit     = busy && (in_phase ? take : (!mode_q && out_slot));
  assign step     = (in_phase || mode_q) ? take : emit;
  assign last     = idx == IDX_W'(TOTAL_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mode_q    <= 1'b0;
      idx       <= '0;
      page_done <= 1'b0;
    end else begin
      page_done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        mode_q <= mode_i;
        idx    <= '0;
      end else if (step) begin
        if (last) begin
          busy      <= 1'b0;
          idx       <= '0;
          page_done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    page_done |=> !page_done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    page_done |-> !busy);

  p_no_spare_take_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !mode_q && !in_phase) |-> !in_ready);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!in_ready && !emit));

endmodule

// File: rtl/nand_spare_gen.sv
module nand_spare_gen
  import nand_fmt_pkg::*;
#(
  parameter int unsigned GROUP_BYTES = 16,
  parameter int unsigned BLK_W       = 10,
  parameter int unsigned PAGE_W      = 7,
  localparam int unsigned GPOS_W     = $clog2(GROUP_BYTES),
  localparam int unsigned HI_W       = BLK_W - 8
) (
  input  logic [GPOS_W-1:0] pos,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W-1:0] page,
  input  byte_t             tag,
  input  logic              ecc_en,
  input  byte_t             ecc_byte,
  output byte_t             spare_b
);

  always_comb begin
    if (pos == GPOS_W'(POS_BLK_LO))      spare_b = blk[7:0];
    else if (pos == GPOS_W'(POS_BLK_HI)) spare_b = {tag[7:HI_W], blk[BLK_W-1:8]};
    else if (pos == GPOS_W'(POS_PAGE))   spare_b = 8'(page);
    else if (pos == GPOS_W'(POS_TAG))    spare_b = tag;
    else                                 spare_b = ecc_en ? ecc_byte : 8'h00;
  end

endmodule

// File: rtl/nand_rd_capture.sv
module nand_rd_capture
  import nand_fmt_pkg::*;
#(
  parameter int unsigned SOFF_W = 6,
  parameter int unsigned GPOS_W = 4,
  parameter int unsigned BLK_W  = 10,
  parameter int unsigned PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [SOFF_W-1:0] soff,
  input  byte_t             din,
  output logic [BLK_W-1:0]  rd_blk,
  output logic [PAGE_W-1:0] rd_page
);

  localparam int unsigned HI_W = BLK_W - 8;

  logic first_grp;
  assign first_grp = soff[SOFF_W-1:GPOS_W] == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_blk  <= '0;
      rd_page <= '0;
    end else if (cap_en && first_grp) begin
      if (soff[GPOS_W-1:0] == GPOS_W'(POS_BLK_LO)) rd_blk[7:0]       <= din;
      if (soff[GPOS_W-1:0] == GPOS_W'(POS_BLK_HI)) rd_blk[BLK_W-1:8] <= din[HI_W-1:0];
      if (soff[GPOS_W-1:0] == GPOS_W'(POS_PAGE))   rd_page           <= din[PAGE_W-1:0];
    end
  end

endmodule

// File: rtl/nand_page_fmt.sv
module nand_page_fmt
  import nand_fmt_pkg::*;
#(
  parameter int unsigned DATA_BYTES   = 2048,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned GROUP_BYTES  = 16,
  parameter int unsigned BLK_W        = 10,
  parameter int unsigned PAGE_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode,
  input  logic [BLK_W-1:0]  blk_num,
  input  logic [PAGE_W-1:0] page_idx,
  input  logic [7:0]        tag,
  input  logic              ecc_en,
  input  logic [7:0]        ecc_byte,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              page_done,
  output logic [BLK_W-1:0]  rd_blk,
  output logic [PAGE_W-1:0] rd_page
);

  localparam int unsigned SECTORS     = DATA_BYTES / SECTOR_BYTES;
  localparam int unsigned SPARE_BYTES = SECTORS * GROUP_BYTES;
  localparam int unsigned TOTAL_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int unsigned IDX_W       = $clog2(TOTAL_BYTES);
  localparam int unsigned SOFF_W      = $clog2(SPARE_BYTES);
  localparam int unsigned GPOS_W      = $clog2(GROUP_BYTES);

  // Page fields held for the whole page.
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] page_q;
  byte_t             tag_q;
  logic              ecc_en_q;

  logic             busy, mode_q, in_phase, take, emit, accept, out_slot;
  logic [IDX_W-1:0] idx;
  logic [SOFF_W-1:0] soff;
  byte_t            spare_b;

  assign out_slot = !out_valid || out_ready;
  // DATA_BYTES is a multiple of SPARE_BYTES, so the low index bits are the spare offset.
  assign soff = idx[SOFF_W-1:0];

  nand_fmt_seq #(
    .DATA_BYTES (DATA_BYTES),
    .TOTAL_BYTES(TOTAL_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode_i   (mode),
    .in_valid (in_valid),
    .out_slot (out_slot),
    .busy     (busy),
    .mode_q   (mode_q),
    .idx      (idx),
    .in_phase (in_phase),
    .in_ready (in_ready),
    .take     (take),
    .emit     (emit),
    .accept   (accept),
    .page_done(page_done)
  );

  nand_spare_gen #(
    .GROUP_BYTES(GROUP_BYTES),
    .BLK_W      (BLK_W),
    .PAGE_W     (PAGE_W)
  ) u_spare (
    .pos     (soff[GPOS_W-1:0]),
    .blk     (blk_q),
    .page    (page_q),
    .tag     (tag_q),
    .ecc_en  (ecc_en_q),
    .ecc_byte(ecc_byte),
    .spare_b (spare_b)
  );

  nand_rd_capture #(
    .SOFF_W(SOFF_W),
    .GPOS_W(GPOS_W),
    .BLK_W (BLK_W),
    .PAGE_W(PAGE_W)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap_en (take && mode_q && !in_phase),
    .soff   (soff),
    .din    (in_data),
    .rd_blk (rd_blk),
    .rd_page(rd_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q    <= '0;
      page_q   <= '0;
      tag_q    <= '0;
      ecc_en_q <= 1'b0;
    end else if (accept) begin
      blk_q    <= blk_num;
      page_q   <= page_idx;
      tag_q    <= tag;
      ecc_en_q <= ecc_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= in_phase ? flip(in_data) : spare_b;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_fields_held_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(blk_q) && $stable(page_q) && $stable(tag_q) && $stable(mode_q))));

  p_read_no_spare_out_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q && !in_phase) |-> !emit);

endmodule

// File: tb/nand_page_fmt_tb.sv
module nand_page_fmt_tb;

  localparam int DATA  = 2048;
  localparam int GRP   = 16;
  localparam int NGRP  = 4;
  localparam int TOTAL = DATA + GRP * NGRP;

  logic       clk = 0;
  logic       rst = 1;
  logic       start = 0, mode = 0, ecc_en = 0;
  logic [9:0] blk_num = '0;
  logic [6:0] page_idx = '0;
  logic [7:0] tag = 8'hFF, ecc_byte = 8'h00;
  logic       in_valid = 0, out_ready = 0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, page_done;
  logic [7:0] out_data;
  logic [9:0] rd_blk;
  logic [6:0] rd_page;

  int checks = 0, failures = 0, cycles = 0;
  bit timed_out = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) timed_out = 1;
  end

  nand_page_fmt u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .blk_num(blk_num),
    .page_idx(page_idx), .tag(tag), .ecc_en(ecc_en), .ecc_byte(ecc_byte),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .page_done(page_done), .rd_blk(rd_blk), .rd_page(rd_page)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    if (seed == 0) return 8'h00;
    if (seed == 1) return 8'h77;
    return 8'((i * seed) + (i >> 3));
  endfunction

  function automatic logic [7:0] spare_ref(input int k, input logic [9:0] b, input logic [6:0] p,
                                           input logic [7:0] t, input bit ee, input logic [7:0] ev);
    case (k)
      0: return b[7:0];
      1: return {t[7:2], b[9:8]};
      2: return {1'b0, p};
      3: return t;
      default: return ee ? ev : 8'h00;
    endcase
  endfunction

  task automatic run_page(input bit rd, input logic [9:0] b, input logic [6:0] p,
                          input logic [7:0] t, input bit ee, input logic [7:0] ev,
                          input int seed, input int vpct, input int rpct);
    logic [7:0] src[$];
    logic [7:0] expq[$];
    int sent = 0, got = 0, dones = 0, iter = 0;
    string req;
    for (int i = 0; i < DATA; i++) begin
      logic [7:0] d = gen(seed, i);
      if (rd) begin src.push_back(~d); expq.push_back(d); end
      else    begin src.push_back(d);  expq.push_back(~d); end
    end
    for (int g = 0; g < NGRP; g++)
      for (int k = 0; k < GRP; k++) begin
        if (rd) src.push_back(spare_ref(k, b, p, t, ee, ev));
        else    expq.push_back(spare_ref(k, b, p, t, ee, ev));
      end
    @(negedge clk);
    start = 1; mode = rd; blk_num = b; page_idx = p; tag = t; ecc_en = ee;
    ecc_byte = ev; in_valid = 0; out_ready = 0;
    while (!timed_out) begin
      @(negedge clk);
      iter++;
      if (page_done) begin
        dones++;
        if (rd) begin
          chk(sent == TOTAL, "R7 read done after last input", sent, TOTAL);
          chk(rd_blk == b, "R10 rd_blk", rd_blk, b);
          chk(rd_page == p, "R10 rd_page", rd_page, p);
        end else begin
          chk(got == TOTAL - 1 && out_valid, "R7 format done with last byte held", got, TOTAL - 1);
        end
      end
      if (dones > 0 && got == expq.size()) break;
      // R6: restart pulse and changing header inputs mid-page must have no effect
      start    = (iter == 40);
      mode     = (iter == 40) ? !rd : 1'($urandom_range(1));
      blk_num  = 10'($urandom);
      page_idx = 7'($urandom);
      tag      = 8'($urandom);
      ecc_en   = 1'($urandom_range(1));
      if (sent < src.size()) begin
        in_valid = ($urandom_range(99) < vpct);
        in_data  = src[sent];
      end else begin
        in_valid = 1;
        in_data  = 8'hA5;
      end
      out_ready = ($urandom_range(99) < rpct);
      #1;
      if (in_valid && in_ready) begin
        if (sent >= src.size()) chk(0, "R5 input taken beyond page", sent, src.size());
        else sent++;
      end
      if (out_valid && out_ready) begin
        if (got < expq.size()) begin
          if (rd) req = "R9 read data";
          else if (got < DATA) req = "R1 inverted data";
          else if ((got - DATA) % GRP < 4) req = "R3 spare header";
          else req = "R4 spare ecc";
          chk(out_data == expq[got], req, out_data, expq[got]);
        end else begin
          chk(0, "R2 extra output byte", got, expq.size());
        end
        got++;
      end
    end
    start = 0; in_valid = 1; in_data = 8'h5A; out_ready = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (page_done) dones++;
      chk(!in_ready, "R5 no input accepted after page", in_ready, 0);
      chk(!out_valid, "R8 no duplicated output", out_valid, 0);
    end
    in_valid = 0;
    chk(dones == 1, "R7 single done pulse", dones, 1);
    chk(got == expq.size(), rd ? "R9 output count" : "R2 output count", got, expq.size());
    chk(sent == (rd ? TOTAL : DATA), rd ? "R9 input count" : "R5 input count", sent, rd ? TOTAL : DATA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!out_valid, "R11 out_valid after reset", out_valid, 0);
    chk(!in_ready, "R11 in_ready after reset", in_ready, 0);
    chk(!page_done, "R11 page_done after reset", page_done, 0);
    if (!timed_out) run_page(0, 10'h000, 7'd0,   8'hFF, 0, 8'h00, 1, 100, 100);
    if (!timed_out) run_page(0, 10'h3C3, 7'd127, 8'hA7, 1, 8'h3C, 7, 60, 50);
    if (!timed_out) run_page(0, 10'h155, 7'd42,  8'hFF, 0, 8'h99, 0, 90, 30);
    if (!timed_out) run_page(1, 10'h2A5, 7'h55,  8'hFF, 1, 8'hC3, 13, 70, 60);
    if (!timed_out) run_page(1, 10'h3FF, 7'd127, 8'h03, 0, 8'h00, 1, 100, 100);
    if (timed_out) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule